// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a single position count for a motor or knob shaft. It either counts clock cycles while enabled, or decodes two phase signals (A and B) from an incremental encoder at double resolution on one phase or quadruple resolution on both. The phase inputs arrive already synchronized and debounced.

The count runs from zero up to a programmable ceiling and wraps in both directions. Each wrap raises a one-cycle pulse. Software sets the mode, enable and ceiling through a small register port. It can write the count directly, and it reads back the count, the ceiling registers and a direction flag. A ceiling write lands either at once or in a shadow register that a software update event copies into the active ceiling.

Register map (2-bit address): 0 control/status, 1 count, 2 active ceiling (write: new ceiling), 3 shadow ceiling (write: update event). Reads are combinational from `addr`. Writes take effect at the clock edge where `wr_en` is high.

Top module: `qenc_counter`

## Requirements
- R1: After reset, control reads 0, count reads 0, and both the active ceiling (address 2) and the shadow ceiling (address 3) read 2^CNT_W-1. `wrap_o` is 0.
- R2: With mode field (control bits 3:2) at 0 and enable (control bit 0) set, the count rises by one on every clock edge. The phase inputs have no effect.
- R3: In mode 1 only edges of A step the count. The step is up when A differs from B after the edge, otherwise down. B edges are ignored.
- R4: In mode 2 only edges of B step the count. The step is up when A equals B after the edge, otherwise down. A edges are ignored.
- R5: In mode 3 every edge of A or B steps the count, using the rules of R3 and R4. A cycle in which A and B both change leaves the count unchanged in every encoder mode.
- R6: Read-only control bit 4 shows the direction of the most recent step: 0 up, 1 down.
- R7: With enable clear the count holds whatever the phase inputs do. Setting enable again resumes counting from the held value.
- R8: An up step from the ceiling (or above it) gives 0, and a down step from 0 gives the ceiling. Each wrap drives `wrap_o` high for exactly the following clock cycle.
- R9: With the preload bit (control bit 1) clear, a ceiling write updates the active and shadow ceilings at once.
- R10: With preload set, a ceiling write changes only the shadow ceiling. Writing address 3 with bit 0 set copies the shadow into the active ceiling.
- R11: A count write above the active ceiling is ignored and sets the sticky error bit (control bit 5). Writing control with bit 5 set clears it. A count write equal to the ceiling is accepted.
- R12: A ceiling write above 2^CNT_W-1 is ignored and sets the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_a | input | 1 | Encoder phase A, synchronized |
| phase_b | input | 1 | Encoder phase B, synchronized |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for read and write |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr` |
| count_o | output | CNT_W | Current count |
| wrap_o | output | 1 | One-cycle pulse after a wrap |

## Verification
Some rules hold on every cycle, and the assertions check these:
- a disabled counter holds its value;
- wraps land on 0 or on the ceiling;
- simultaneous phase changes never step the count;
- the direction flag follows each step;
- a rejected count write leaves the count untouched;
- a preloaded ceiling write leaves the active ceiling unchanged.

Other behaviour needs whole sequences, so only the bench scenarios show it. These cover the decoding of full forward and reverse phase cycles in each resolution, the exact net count after a run, and the hand-over of the shadow ceiling on an update event.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    MODE_CLK = 2'd0,
    MODE_X2A = 2'd1,
    MODE_X2B = 2'd2,
    MODE_X4  = 2'd3
  } qenc_mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] REG_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] REG_CEIL  = 2'd2;
  localparam logic [ADDR_W-1:0] REG_EVENT = 2'd3;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_PRE  = 1;
  localparam int CTRL_MODE = 2;
  localparam int CTRL_DIR  = 4;
  localparam int CTRL_ERR  = 5;
  localparam int CTRL_W    = 6;

  typedef struct packed {
    logic step;
    logic up;
  } qenc_step_t;

  // Decide whether this cycle steps the count and in which direction.
  function automatic qenc_step_t qenc_decode(qenc_mode_e mode, logic en,
                                             logic a, logic b,
                                             logic a_q, logic b_q);
    qenc_step_t r;
    logic ea, eb;
    ea = a ^ a_q;
    eb = b ^ b_q;
    r = '0;
    if (en) begin
      case (mode)
        MODE_CLK: begin
          r.step = 1'b1;
          r.up   = 1'b1;
        end
        MODE_X2A: if (ea && !eb) begin
          r.step = 1'b1;
          r.up   = a ^ b;
        end
        MODE_X2B: if (eb && !ea) begin
          r.step = 1'b1;
          r.up   = ~(a ^ b);
        end
        default: if (ea ^ eb) begin
          r.step = 1'b1;
          r.up   = ea ? (a ^ b) : ~(a ^ b);
        end
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/qenc_phase_decode.sv
module qenc_phase_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  qenc_mode_e mode,
  input  logic       en,
  input  logic       phase_a,
  input  logic       phase_b,
  output logic       step,
  output logic       step_up
);

  // Previous phase levels follow the inputs continuously, also in reset,
  // so enabling or changing mode never sees a stale edge.
  logic a_q, b_q;
  qenc_step_t dec;

  always_ff @(posedge clk) begin
    a_q <= phase_a;
    b_q <= phase_b;
  end

  always_comb begin
    dec     = qenc_decode(mode, en, phase_a, phase_b, a_q, b_q);
    step    = dec.step;
    step_up = dec.up;
  end

endmodule

// File: rtl/qenc_regfile.sv
module qenc_regfile
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  count,
  input  logic              dir,
  output logic [DATA_W-1:0] rd_data,
  output logic              en,
  output logic              preload,
  output qenc_mode_e        mode,
  output logic              err,
  output logic [CNT_W-1:0]  ceil_act,
  output logic [CNT_W-1:0]  ceil_shd,
  output logic              load_ok,
  output logic              load_rej,
  output logic [CNT_W-1:0]  load_val,
  output logic              ceil_wr,
  output logic              upd_evt
);

  localparam logic [CNT_W-1:0] CEIL_MAX = {CNT_W{1'b1}};

  logic cnt_fits, ceil_fits;
  logic wr_ctrl, wr_cnt, wr_ceil, wr_evt;
  logic [CTRL_W-1:0] ctrl_view;

  assign cnt_fits  = wr_data <= DATA_W'(ceil_act);
  assign ceil_fits = wr_data <= DATA_W'(CEIL_MAX);
  assign wr_ctrl   = wr_en && (addr == REG_CTRL);
  assign wr_cnt    = wr_en && (addr == REG_COUNT);
  assign wr_ceil   = wr_en && (addr == REG_CEIL);
  assign wr_evt    = wr_en && (addr == REG_EVENT);

  assign load_ok  = wr_cnt && cnt_fits;
  assign load_rej = wr_cnt && !cnt_fits;
  assign load_val = wr_data[CNT_W-1:0];
  assign ceil_wr  = wr_ceil && ceil_fits;
  assign upd_evt  = wr_evt && wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      preload  <= 1'b0;
      mode     <= MODE_CLK;
      err      <= 1'b0;
      ceil_act <= CEIL_MAX;
      ceil_shd <= CEIL_MAX;
    end else begin
      if (wr_ctrl) begin
        en      <= wr_data[CTRL_EN];
        preload <= wr_data[CTRL_PRE];
        mode    <= qenc_mode_e'(wr_data[CTRL_MODE +: 2]);
        if (wr_data[CTRL_ERR]) err <= 1'b0;
      end
      if (load_rej || (wr_ceil && !ceil_fits)) err <= 1'b1;
      if (ceil_wr) begin
        ceil_shd <= wr_data[CNT_W-1:0];
        if (!preload) ceil_act <= wr_data[CNT_W-1:0];
      end
      if (upd_evt) ceil_act <= ceil_shd;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EN]          = en;
    ctrl_view[CTRL_PRE]         = preload;
    ctrl_view[CTRL_MODE +: 2]   = mode;
    ctrl_view[CTRL_DIR]         = dir;
    ctrl_view[CTRL_ERR]         = err;
    case (addr)
      REG_CTRL:  rd_data = DATA_W'(ctrl_view);
      REG_COUNT: rd_data = DATA_W'(count);
      REG_CEIL:  rd_data = DATA_W'(ceil_act);
      default:   rd_data = DATA_W'(ceil_shd);
    endcase
  end

endmodule

// File: rtl/qenc_count_core.sv
module qenc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             step_up,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] ceil,
  output logic [CNT_W-1:0] count,
  output logic             dir,
  output logic             wrap_evt,
  output logic             wrap_q
);

  // Returns {wrapped, next value} for one step.
  function automatic logic [CNT_W:0] next_pos(logic [CNT_W-1:0] cur,
                                              logic [CNT_W-1:0] top,
                                              logic up);
    if (up) begin
      if (cur >= top) return {1'b1, {CNT_W{1'b0}}};
      return {1'b0, cur + CNT_W'(1)};
    end
    if (cur == '0) return {1'b1, top};
    return {1'b0, cur - CNT_W'(1)};
  endfunction

  logic [CNT_W:0] nx;

  assign nx       = next_pos(count, ceil, step_up);
  assign wrap_evt = step && !load && nx[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      dir    <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= wrap_evt;
      if (load) begin
        count <= load_val;
      end else if (step) begin
        count <= nx[CNT_W-1:0];
        dir   <= !step_up;
      end
    end
  end

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_a,
  input  logic              phase_b,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              wrap_o
);

  logic             en, preload, err, dir;
  qenc_mode_e       mode;
  logic [CNT_W-1:0] ceil_act, ceil_shd, load_val, count;
  logic             load_ok, load_rej, ceil_wr, upd_evt;
  logic             step, step_up, wrap_evt;

  qenc_regfile #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .count(count), .dir(dir), .rd_data(rd_data), .en(en), .preload(preload),
    .mode(mode), .err(err), .ceil_act(ceil_act), .ceil_shd(ceil_shd),
    .load_ok(load_ok), .load_rej(load_rej), .load_val(load_val),
    .ceil_wr(ceil_wr), .upd_evt(upd_evt)
  );

  qenc_phase_decode u_dec (
    .clk(clk), .mode(mode), .en(en), .phase_a(phase_a), .phase_b(phase_b),
    .step(step), .step_up(step_up)
  );

  qenc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .step_up(step_up), .load(load_ok),
    .load_val(load_val), .ceil(ceil_act), .count(count), .dir(dir),
    .wrap_evt(wrap_evt), .wrap_q(wrap_o)
  );

  assign count_o = count;

endmodule

// File: rtl/qenc_counter_chk.sv
module qenc_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a,
  input logic             b,
  input logic [1:0]       mode,
  input logic             en,
  input logic             preload,
  input logic             dir,
  input logic             err,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] ceil_act,
  input logic             wrap_o,
  input logic             step,
  input logic             step_up,
  input logic             load_ok,
  input logic             load_rej,
  input logic             ceil_wr,
  input logic             upd_evt
);

  a_r7_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_ok) |=> $stable(count_o));

  a_r2_clock_mode_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && step) |-> step_up);

  a_r5_both_change_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && a != $past(a) && b != $past(b)) |-> !step);

  a_r6_dir_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_ok) |=> (dir == !$past(step_up)));

  a_r8_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_up && !load_ok && count_o >= ceil_act) |=> (count_o == '0 && wrap_o));

  a_r8_down_wrap_ceil: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_up && !load_ok && count_o == '0 && !ceil_wr && !upd_evt)
      |=> (count_o == $past(ceil_act) && wrap_o));

  a_r10_preload_holds_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (ceil_wr && preload && !upd_evt) |=> $stable(ceil_act));

  a_r11_reject_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rej && !step) |=> ($stable(count_o) && err));

endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a(phase_a), .b(phase_b), .mode(mode), .en(en),
  .preload(preload), .dir(dir), .err(err), .count_o(count_o),
  .ceil_act(ceil_act), .wrap_o(wrap_o), .step(step), .step_up(step_up),
  .load_ok(load_ok), .load_rej(load_rej), .ceil_wr(ceil_wr), .upd_evt(upd_evt)
);

// File: tb/qenc_counter_bench.sv
module qenc_counter_bench;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 32;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CEIL = 2'd2, A_SHD = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, pa = 1'b0, pb = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0] count_o;
  logic wrap_o;

  qenc_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_qenc_counter (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .count_o(count_o),
    .wrap_o(wrap_o)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, wraps = 0, w0 = 0;
  bit reported = 0;

  typedef struct { logic [DATA_W-1:0] exp; string tag; } item_t;
  item_t sbq[$];
  event rd_ev;

  always @(negedge clk) if (rst_n && wrap_o) wraps++;

  task automatic chk(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp,
                     input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
    $finish;
  endtask

  // Driver: pushes the expected value and presents the address.
  task automatic rd(input logic [1:0] a, input logic [DATA_W-1:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.exp = exp;
    it.tag = tag;
    sbq.push_back(it);
    ->rd_ev;
    #2;
  endtask

  // Monitor: pops and compares after read data settles.
  initial begin
    item_t it;
    forever begin
      @(rd_ev);
      #1;
      it = sbq.pop_front();
      chk(rd_data, it.exp, it.tag);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic ab(input logic a, input logic b);
    @(negedge clk);
    pa = a; pb = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_CNT, 32'h0, "R1 count");
    rd(A_CEIL, 32'hFFFF, "R1 ceiling");
    rd(A_SHD, 32'hFFFF, "R1 shadow");
    chk(wrap_o, 1'b0, "R1 wrap_o");
    // R9 immediate ceiling
    wr(A_CEIL, 9);
    rd(A_CEIL, 9, "R9 active ceiling");
    // R2 clock mode, phases ignored: 4 increments
    wr(A_CTRL, 32'h1);
    pa = 1'b1; pb = 1'b1;
    repeat (3) @(posedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 4, "R2 clock count");
    rd(A_CTRL, 32'h0, "R6 dir up in clock mode");
    pa = 1'b0; pb = 1'b0;
    // R7 hold while disabled
    repeat (5) @(posedge clk);
    rd(A_CNT, 4, "R7 hold");
    // R8 up wrap: 7 increments from 4 with ceiling 9 -> 1
    w0 = wraps;
    wr(A_CTRL, 32'h1);
    repeat (6) @(posedge clk);
    wr(A_CTRL, 32'h0);
    rd(A_CNT, 1, "R8 up wrap count");
    chk(wraps - w0, 1, "R8 one wrap pulse");
    // R3 mode 1
    wr(A_CTRL, 32'h5);
    wr(A_CNT, 5);
    ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
    rd(A_CNT, 7, "R3 forward");
    rd(A_CTRL, 32'h05, "R6 dir up mode1");
    ab(0, 1); ab(1, 1); ab(1, 0); ab(0, 0);
    rd(A_CNT, 5, "R3 reverse");
    rd(A_CTRL, 32'h15, "R6 dir down mode1");
    // R4 mode 2
    wr(A_CTRL, 32'h9);
    ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
    rd(A_CNT, 7, "R4 forward");
    rd(A_CTRL, 32'h09, "R6 dir up mode2");
    wr(A_CNT, 0);
    w0 = wraps;
    ab(0, 1);
    rd(A_CNT, 9, "R8 down wrap to ceiling");
    rd(A_CTRL, 32'h19, "R6 dir down mode2");
    chk(wraps - w0, 1, "R8 down wrap pulse");
    ab(1, 1); ab(1, 0); ab(0, 0);
    rd(A_CNT, 8, "R4 reverse");
    // R5 mode 3
    wr(A_CTRL, 32'hD);
    wr(A_CNT, 0);
    ab(1, 0); ab(1, 1); ab(0, 1); ab(0, 0);
    rd(A_CNT, 4, "R5 x4 forward");
    ab(1, 1); ab(0, 0);
    rd(A_CNT, 4, "R5 simultaneous change ignored");
    ab(0, 1); ab(1, 1); ab(1, 0); ab(0, 0);
    rd(A_CNT, 0, "R5 x4 reverse");
    rd(A_CTRL, 32'h1D, "R6 dir down mode3");
    // R7 disabled in mode 3, then resume
    wr(A_CTRL, 32'hC);
    ab(1, 0); ab(1, 1);
    rd(A_CNT, 0, "R7 disabled phases");
    wr(A_CTRL, 32'hD);
    ab(0, 1);
    rd(A_CNT, 1, "R7 resume");
    ab(0, 0);
    rd(A_CNT, 2, "R7 resume second step");
    // R10 preload
    wr(A_CTRL, 32'h2);
    wr(A_CEIL, 5);
    rd(A_CEIL, 9, "R10 active held");
    rd(A_SHD, 5, "R10 shadow");
    wr(A_SHD, 32'h0);
    rd(A_CEIL, 9, "R10 event bit clear no copy");
    wr(A_SHD, 32'h1);
    rd(A_CEIL, 5, "R10 update event");
    // R11 reject count above ceiling
    wr(A_CNT, 7);
    rd(A_CNT, 2, "R11 rejected count");
    rd(A_CTRL, 32'h22, "R11 error set");
    wr(A_CTRL, 32'h22);
    rd(A_CTRL, 32'h02, "R11 error cleared");
    wr(A_CNT, 5);
    rd(A_CNT, 5, "R11 equal accepted");
    // R12 ceiling above maximum
    wr(A_CEIL, 32'h10000);
    rd(A_SHD, 5, "R12 shadow unchanged");
    rd(A_CTRL, 32'h22, "R12 error set");
    wr(A_CTRL, 32'h20);
    wr(A_CEIL, 32'hFFFF);
    rd(A_CEIL, 32'hFFFF, "R12 max accepted");
    rd(A_CTRL, 32'h00, "R12 ctrl after clear");
    repeat (2) @(posedge clk);
    report();
  end

endmodule